// File: doc/BRIEF.md
# Polar Successive-Cancellation Processing Element

This block is the arithmetic node of a successive-cancellation polar decoder. Each cycle it may accept two signed fixed-point log-likelihood ratios, a mode select and a fed-back partial-sum bit. It then produces one updated LLR, either through the min-sum check-node rule or through the partial-sum-controlled add/subtract rule. The rule that applies to edge (i, j) of the factor graph follows from bit j of the index i. A clear bit selects the check-node rule, which combines edges i and i+2^j of the next stage. A set bit selects the add/subtract rule, which combines edges i-2^j and i. The surrounding scheduler picks the mode and routes the operands. The element does not track the graph itself.

The same result also feeds a hard-decision stage. When the element computes a final, stage-0 LLR, the decided bit output carries the bit estimate for that position. A frozen flag marks positions known to be zero, and for those the estimate is forced to 0. All results are registered once, and an output valid flag follows the input valid flag with the same one-cycle delay.

Top module: `sc_pe`

## Requirements
- R1: While reset is asserted, out_valid, llr_out and bit_out are all 0.
- R2: A sample accepted with in_valid high at a clock edge appears on llr_out and bit_out after that edge, with out_valid high. An edge with in_valid low leaves out_valid low.
- R3: An edge with in_valid low leaves llr_out and bit_out at their previous values, whatever the other inputs are.
- R4: mode = 0 selects the check-node rule and mode = 1 selects the add/subtract rule.
- R5: In check-node mode, the output magnitude is the smaller of |llr_a| and |llr_b|. The output is negative when exactly one operand is negative, and positive otherwise.
- R6: The magnitude of the most negative code (-2^(Q-1)) is taken as 2^(Q-1)-1.
- R7: In add/subtract mode, the output is llr_b + llr_a when psum = 0 and llr_b - llr_a when psum = 1.
- R8: The add/subtract result saturates to the range [-2^(Q-1), 2^(Q-1)-1] and never wraps.
- R9: With frozen = 0, bit_out is 0 when the registered llr_out is strictly positive. It is 1 when llr_out is zero or negative.
- R10: With frozen = 1, bit_out is 0 for any LLR value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| mode | input | 1 | 0: check-node rule, 1: add/subtract rule |
| llr_a | input | Q | First LLR operand, two's complement |
| llr_b | input | Q | Second LLR operand, two's complement |
| psum | input | 1 | Partial-sum bit steering the add/subtract rule |
| frozen | input | 1 | Position is frozen; force the decided bit to 0 |
| out_valid | output | 1 | Registered copy of in_valid |
| llr_out | output | Q | Registered updated LLR |
| bit_out | output | 1 | Registered hard decision on llr_out |

## Verification
Every result is due exactly one rising edge after the edge that captures the stimulus. This holds for the LLR, the decided bit and the valid flag alike. The bench changes inputs on the falling edge and samples the outputs on the next falling edge. At that point the single register stage has updated and the inputs have not yet moved again. Back-to-back samples are checked one per cycle. For idle cycles, the bench reads the outputs on every falling edge while in_valid is low, to confirm that nothing moved.

// File: rtl/sc_pe_pkg.sv
package sc_pe_pkg;

    typedef enum logic {
        PE_CHECK = 1'b0,
        PE_ADDSUB = 1'b1
    } pe_mode_e;

endpackage

// File: rtl/llr_mag.sv
module llr_mag #(
    parameter int Q = 8
) (
    input  logic signed [Q-1:0] x,
    output logic        [Q-2:0] mag
);
    localparam logic [Q-1:0] MOST_NEG = {1'b1, {(Q-1){1'b0}}};

    logic [Q-1:0] negated;

    always_comb begin
        negated = -x;
        if (x == MOST_NEG)
            mag = {(Q-1){1'b1}};
        else if (x[Q-1])
            mag = negated[Q-2:0];
        else
            mag = x[Q-2:0];
    end
endmodule

// File: rtl/llr_fnode.sv
module llr_fnode #(
    parameter int Q = 8
) (
    input  logic signed [Q-1:0] a,
    input  logic signed [Q-1:0] b,
    output logic signed [Q-1:0] res
);
    localparam int MW = Q - 1;

    logic signed [Q-1:0] ops [2];
    logic [MW-1:0] mags [2];
    logic [MW-1:0] smaller;
    logic flip;

    assign ops[0] = a;
    assign ops[1] = b;

    for (genvar k = 0; k < 2; k++) begin : g_mag
        llr_mag #(.Q(Q)) u_mag (.x(ops[k]), .mag(mags[k]));
    end

    always_comb begin
        smaller = (mags[0] < mags[1]) ? mags[0] : mags[1];
        flip    = a[Q-1] ^ b[Q-1];
        res     = flip ? -$signed({1'b0, smaller}) : $signed({1'b0, smaller});
    end
endmodule

// File: rtl/llr_gnode.sv
module llr_gnode #(
    parameter int Q = 8
) (
    input  logic signed [Q-1:0] a,
    input  logic signed [Q-1:0] b,
    input  logic                psum,
    output logic signed [Q-1:0] res
);
    localparam logic [Q-1:0] TOP_POS = {1'b0, {(Q-1){1'b1}}};
    localparam logic [Q-1:0] TOP_NEG = {1'b1, {(Q-1){1'b0}}};

    logic signed [Q:0] ax, bx, wide;

    always_comb begin
        ax   = {a[Q-1], a};
        bx   = {b[Q-1], b};
        wide = psum ? (bx - ax) : (bx + ax);
        if (wide[Q] != wide[Q-1])
            res = wide[Q] ? TOP_NEG : TOP_POS;
        else
            res = wide[Q-1:0];
    end
endmodule

// File: rtl/hard_decide.sv
module hard_decide #(
    parameter int Q = 8
) (
    input  logic signed [Q-1:0] llr,
    input  logic                frozen,
    output logic                bit_est
);
    always_comb begin
        if (frozen)
            bit_est = 1'b0;
        else
            bit_est = llr[Q-1] || (llr == '0);
    end
endmodule

// File: rtl/sc_pe.sv
module sc_pe
    import sc_pe_pkg::*;
#(
    parameter int Q = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                mode,
    input  logic signed [Q-1:0] llr_a,
    input  logic signed [Q-1:0] llr_b,
    input  logic                psum,
    input  logic                frozen,
    output logic                out_valid,
    output logic signed [Q-1:0] llr_out,
    output logic                bit_out
);
    pe_mode_e            sel;
    logic signed [Q-1:0] f_res, g_res, nxt_llr;
    logic                nxt_bit;

    assign sel = pe_mode_e'(mode);

    llr_fnode #(.Q(Q)) u_fnode (.a(llr_a), .b(llr_b), .res(f_res));
    llr_gnode #(.Q(Q)) u_gnode (.a(llr_a), .b(llr_b), .psum(psum), .res(g_res));

    always_comb begin
        unique case (sel)
            PE_CHECK:  nxt_llr = f_res;
            PE_ADDSUB: nxt_llr = g_res;
            default:   nxt_llr = f_res;
        endcase
    end

    hard_decide #(.Q(Q)) u_dec (.llr(nxt_llr), .frozen(frozen), .bit_est(nxt_bit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            llr_out   <= '0;
            bit_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                llr_out <= nxt_llr;
                bit_out <= nxt_bit;
            end
        end
    end

    // R5
    f_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(mode) && ($past(llr_a[Q-1]) == $past(llr_b[Q-1])))
        |-> !llr_out[Q-1]);

    // R8
    g_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) && !$past(psum) && !$past(llr_a[Q-1]) && !$past(llr_b[Q-1]))
        |-> !llr_out[Q-1]);

    // R8
    g_neg_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) && !$past(psum) && $past(llr_a[Q-1]) && $past(llr_b[Q-1]))
        |-> llr_out[Q-1]);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(llr_out) && $stable(bit_out) && !out_valid));

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(frozen)) |-> !bit_out);

    // R9
    decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(frozen) && llr_out[Q-1]) |-> bit_out);

endmodule

// File: tb/sc_pe_test.sv
`timescale 1ns/1ps
module sc_pe_test;
    localparam int Q = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                mode = 1'b0;
    logic signed [Q-1:0] llr_a = '0;
    logic signed [Q-1:0] llr_b = '0;
    logic                psum = 1'b0;
    logic                frozen = 1'b0;
    logic                out_valid;
    logic signed [Q-1:0] llr_out;
    logic                bit_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sc_pe #(.Q(Q)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .llr_a(llr_a), .llr_b(llr_b), .psum(psum), .frozen(frozen),
        .out_valid(out_valid), .llr_out(llr_out), .bit_out(bit_out)
    );

    // fields: [27] mode, [26] psum, [25] frozen, [24:17] a, [16:9] b, [8:1] expected llr, [0] expected bit
    localparam logic [27:0] VEC [0:13] = '{
        {1'b0, 1'b0, 1'b0, 8'h05, 8'hFD, 8'hFD, 1'b1}, // R5: 5,-3 -> -3
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h80, 8'h7F, 1'b0}, // R6: -128,-128 -> 127
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h64, 8'h9C, 1'b1}, // R6: -128,100 -> -100
        {1'b0, 1'b0, 1'b0, 8'h00, 8'hCE, 8'h00, 1'b1}, // R9: zero result decides 1
        {1'b0, 1'b0, 1'b0, 8'hF9, 8'hF7, 8'h07, 1'b0}, // R5: -7,-9 -> 7
        {1'b1, 1'b0, 1'b0, 8'h64, 8'h64, 8'h7F, 1'b0}, // R8: 100+100 saturates
        {1'b1, 1'b0, 1'b0, 8'h9C, 8'h9C, 8'h80, 1'b1}, // R8: -100-100 saturates
        {1'b1, 1'b1, 1'b0, 8'h80, 8'h0A, 8'h7F, 1'b0}, // R8: 10-(-128) saturates
        {1'b1, 1'b1, 1'b0, 8'h32, 8'h14, 8'hE2, 1'b1}, // R7: 20-50 -> -30
        {1'b1, 1'b0, 1'b0, 8'hEC, 8'h14, 8'h00, 1'b1}, // R7: 20+(-20) -> 0
        {1'b1, 1'b1, 1'b1, 8'h7F, 8'h80, 8'h80, 1'b0}, // R10: frozen on negative
        {1'b0, 1'b0, 1'b1, 8'hFC, 8'h06, 8'hFC, 1'b0}, // R10: frozen in f mode
        {1'b1, 1'b1, 1'b0, 8'h03, 8'h03, 8'h00, 1'b1}, // R9: 3-3 -> 0 decides 1
        {1'b1, 1'b0, 1'b0, 8'hFF, 8'h7F, 8'h7E, 1'b0}  // R7: 127+(-1) -> 126
    };

    function automatic int ref_mag(int v);
        if (v == -(2 ** (Q - 1))) return 2 ** (Q - 1) - 1;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int ref_llr(bit m, bit p, int a, int b);
        int r;
        if (!m) begin
            r = (ref_mag(a) < ref_mag(b)) ? ref_mag(a) : ref_mag(b);
            if ((a < 0) != (b < 0)) r = -r;
        end else begin
            r = p ? (b - a) : (b + a);
            if (r > 2 ** (Q - 1) - 1) r = 2 ** (Q - 1) - 1;
            if (r < -(2 ** (Q - 1))) r = -(2 ** (Q - 1));
        end
        return r;
    endfunction

    function automatic bit ref_bit(bit fz, int r);
        if (fz) return 1'b0;
        return (r > 0) ? 1'b0 : 1'b1;
    endfunction

    task automatic check_out(string tag, bit exp_v, int exp_llr, bit exp_bit);
        checks++;
        if (out_valid !== exp_v || int'(llr_out) != exp_llr || bit_out !== exp_bit) begin
            errors++;
            $display("FAIL %s: got valid=%0b llr=%0d bit=%0b, expected valid=%0b llr=%0d bit=%0b",
                     tag, out_valid, llr_out, bit_out, exp_v, exp_llr, exp_bit);
        end
    endtask

    task automatic apply(bit m, bit p, bit fz, int a, int b);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        psum     = p;
        frozen   = fz;
        llr_a    = Q'(a);
        llr_b    = Q'(b);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got no end of run, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with busy inputs
        in_valid = 1'b1; mode = 1'b1; llr_a = 8'sd40; llr_b = 8'sd40;
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0, 0, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: each result due one edge later (R2, R4)
        for (int i = 0; i < 14; i++) begin
            logic [27:0] v;
            v = VEC[i];
            apply(v[27], v[26], v[25], int'($signed(v[24:17])), int'($signed(v[16:9])));
            @(negedge clk);
            check_out(v[27] ? "R4 R7 R8 R9 R10" : "R4 R5 R6 R9 R10",
                      1'b1, int'($signed(v[8:1])), v[0]);
        end

        // random back-to-back samples against integer reference (R2, R5, R7)
        for (int i = 0; i < 400; i++) begin
            bit m, p, fz;
            int a, b, r;
            m  = 1'($urandom);
            p  = 1'($urandom);
            fz = (($urandom % 5) == 0);
            a  = int'($signed(8'($urandom)));
            b  = int'($signed(8'($urandom)));
            apply(m, p, fz, a, b);
            r = ref_llr(m, p, a, b);
            @(negedge clk);
            check_out(m ? "R2 R7" : "R2 R5", 1'b1, r, ref_bit(fz, r));
        end

        // R3: idle cycles with changing inputs keep the last result
        apply(1'b1, 1'b1, 1'b0, 60, 10);
        @(negedge clk);
        check_out("R7", 1'b1, -50, 1'b1);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b0;
            mode = 1'b0; frozen = 1'b1;
            llr_a = Q'(5 + i); llr_b = Q'(9 + i);
            @(negedge clk);
            check_out("R3", 1'b0, -50, 1'b1);
        end

        // R9 zero result in f mode via zero operand b
        apply(1'b0, 1'b0, 1'b0, -90, 0);
        @(negedge clk);
        check_out("R9", 1'b1, 0, 1'b1);

        // R2: valid drops after one idle edge
        in_valid = 1'b0;
        @(negedge clk);
        check_out("R2", 1'b0, 0, 1'b1);

        // R1: reset mid-run clears outputs
        apply(1'b1, 1'b0, 1'b0, 30, 30);
        @(negedge clk);
        check_out("R7", 1'b1, 60, 1'b0);
        rst_n = 1'b0;
        #1;
        check_out("R1", 1'b0, 0, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule